// File: doc/BRIEF.md
# Pipelined Montgomery Modular Multiplier

This block returns the Montgomery product Z = A·B·2^-N mod M for an odd N-bit modulus M. Each operation is presented with its own modulus and the matching negated inverse M' = -M^-1 mod 2^N, so the modulus can change from one operation to the next with no reload step. Operands must already be in Montgomery form. Converting into or out of that form, and deriving M', are the job of the surrounding logic.

Only the parts of the three products that reach the result are built. T = A·B is formed in full and split at bit N. Q is the low half of T0·M'. Only the high half S1 of Q·M is kept. The discarded low half of S is replaced by a single carry that is 1 exactly when T0 is nonzero. Z = T1 + S1 + carry is held one bit wider than N, and M is subtracted from it at most once.

The block is a two-stage pipeline. It accepts one operation per clock and produces one result per clock, two cycles after issue. Its main use is long chains of back-to-back squarings.

Top module: `rmm_core`

## Requirements
- R1: An operation sampled with `in_valid` high at a rising edge produces `out_valid` high exactly two rising edges later. A new operation may be issued on every cycle.
- R2: For odd M with A < M and B < M, `result` equals A·B·2^-N mod M, with N = 64 by default.
- R3: Every returned `result` is strictly less than the modulus that was issued with it.
- R4: When the low N bits of A·B are all zero, `result` is the high N bits of A·B, reduced below M. For example, A = 2^32 and B = 2^32 give 1, and A = 0 gives 0.
- R5: Modulus and M' are taken per operation. Back-to-back operations with different moduli each return the product for their own modulus.
- R6: While `rst_n` is low, and on the first cycle after it, `out_valid` is low.
- R7: When M is close to 2^N and both operands equal M-1, the intermediate sum does not wrap, and the result is still exact.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low two edges later, and no result appears that was not issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present on the operand inputs |
| op_a | input | N | Multiplicand A, less than `modulus` |
| op_b | input | N | Multiplier B, less than `modulus` |
| modulus | input | N | Odd modulus M |
| m_neg_inv | input | N | -M^-1 mod 2^N for this modulus |
| out_valid | output | 1 | `result` holds a finished product |
| result | output | N | A·B·2^-N mod M |

## Verification
The bench builds moduli with the top bit set, so that the sum before the final subtraction can reach past 2^N. A design that drops the extra sum bit returns values off by 2^N mod M. Operands whose product has a zero low half are checked next. A design that always adds the carry returns T1+1 there. A design that adds the carry on the wrong condition disagrees on almost every random case. The bench also interleaves moduli on consecutive cycles. A design that takes the modulus or M' from the wrong pipeline stage mixes the two operations and fails the reference. Idle gaps between issues expose a valid bit that leaks or shifts by a cycle.

// File: rtl/rmm_pkg.sv
package rmm_pkg;
    localparam int unsigned RMM_DEF_WIDTH = 64;
    localparam int unsigned RMM_LATENCY   = 2;
endpackage

// File: rtl/rmm_lo_mul.sv
module rmm_lo_mul #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] mul_x,
    input  logic [W-1:0] mul_y,
    output logic [W-1:0] prod_lo
);
    // Only the low W bits are needed; truncation lets synthesis prune the rest.
    always_comb begin
        prod_lo = mul_x * mul_y;
    end
endmodule

// File: rtl/rmm_full_mul.sv
module rmm_full_mul #(
    parameter int unsigned W = 64,
    parameter bit          HI_ONLY = 1'b0
) (
    input  logic [W-1:0]   mul_x,
    input  logic [W-1:0]   mul_y,
    output logic [W-1:0]   prod_hi,
    output logic [W-1:0]   prod_lo
);
    localparam int unsigned PW = 2 * W;
    logic [PW-1:0] prod_full;

    always_comb begin
        prod_full = PW'(mul_x) * PW'(mul_y);
        prod_hi   = prod_full[PW-1:W];
    end

    generate
        if (HI_ONLY) begin : g_hi_only
            assign prod_lo = '0;
        end else begin : g_both
            assign prod_lo = prod_full[W-1:0];
        end
    endgenerate
endmodule

// File: rtl/rmm_fold.sv
module rmm_fold #(
    parameter int unsigned W = 64
) (
    input  logic         chk_en,
    input  logic [W-1:0] hi_t,
    input  logic [W-1:0] hi_s,
    input  logic         low_cy,
    input  logic [W-1:0] mod_m,
    output logic [W-1:0] folded
);
    localparam int unsigned SW = W + 1;
    logic [SW-1:0] sum_w;
    logic [SW-1:0] diff_w;

    always_comb begin
        sum_w  = {1'b0, hi_t} + {1'b0, hi_s} + SW'(low_cy);
        diff_w = sum_w - {1'b0, mod_m};
        folded = (sum_w >= {1'b0, mod_m}) ? diff_w[W-1:0] : sum_w[W-1:0];
    end

    // R7: with reduced operands the wide sum stays below 2M, so one subtraction suffices
    always_comb begin
        if (chk_en) begin
            a_r7_sum_below_twice_mod: assert ({1'b0, sum_w} < {1'b0, mod_m, 1'b0})
                else $error("R7 sum exceeds 2M");
        end
    end
endmodule

// File: rtl/rmm_core.sv
module rmm_core #(
    parameter int unsigned N = rmm_pkg::RMM_DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [N-1:0] modulus,
    input  logic [N-1:0] m_neg_inv,
    output logic         out_valid,
    output logic [N-1:0] result
);
    typedef struct packed {
        logic         vld;
        logic [N-1:0] t_hi;
        logic         t_lo_nz;
        logic [N-1:0] q_val;
        logic [N-1:0] m_val;
    } stg1_t;

    typedef struct packed {
        logic         vld;
        logic [N-1:0] z_val;
    } stg2_t;

    typedef struct packed {
        stg1_t s1;
        stg2_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [N-1:0] t_hi_w, t_lo_w, q_w, s_hi_w, s_lo_unused, z_w;

    rmm_full_mul #(.W(N), .HI_ONLY(1'b0)) u_mul_ab (
        .mul_x   (op_a),
        .mul_y   (op_b),
        .prod_hi (t_hi_w),
        .prod_lo (t_lo_w)
    );

    rmm_lo_mul #(.W(N)) u_mul_q (
        .mul_x   (t_lo_w),
        .mul_y   (m_neg_inv),
        .prod_lo (q_w)
    );

    rmm_full_mul #(.W(N), .HI_ONLY(1'b1)) u_mul_qm (
        .mul_x   (pipe_q.s1.q_val),
        .mul_y   (pipe_q.s1.m_val),
        .prod_hi (s_hi_w),
        .prod_lo (s_lo_unused)
    );

    rmm_fold #(.W(N)) u_fold (
        .chk_en  (pipe_q.s1.vld),
        .hi_t    (pipe_q.s1.t_hi),
        .hi_s    (s_hi_w),
        .low_cy  (pipe_q.s1.t_lo_nz),
        .mod_m   (pipe_q.s1.m_val),
        .folded  (z_w)
    );

    always_comb begin
        pipe_d            = pipe_q;
        pipe_d.s1.vld     = in_valid;
        pipe_d.s1.t_hi    = t_hi_w;
        pipe_d.s1.t_lo_nz = |t_lo_w;
        pipe_d.s1.q_val   = q_w;
        pipe_d.s1.m_val   = modulus;
        pipe_d.s2.vld     = pipe_q.s1.vld;
        pipe_d.s2.z_val   = z_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s2.vld;
    assign result    = pipe_q.s2.z_val;

    a_r1_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid)
        else $error("R1 result missing two cycles after issue");

    a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid)
        else $error("R8 result without issue");

    a_r3_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (result < $past(modulus, 2)))
        else $error("R3 result not reduced");

    a_r4_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a == '0) |-> ##2 (result == '0))
        else $error("R4 zero operand gave nonzero result");
endmodule

// File: tb/tb_rmm_core.sv
`timescale 1ns/1ps
module tb_rmm_core;
    localparam int unsigned N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [N-1:0] op_a = '0, op_b = '0, modulus = 64'd1, m_neg_inv = '0;
    logic         out_valid;
    logic [N-1:0] result;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;
    bit          finished = 1'b0;

    logic [N-1:0] exp_val_q[$];
    int unsigned  exp_cyc_q[$];
    string        exp_tag_q[$];

    always #10 clk = ~clk;

    rmm_core #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .modulus(modulus), .m_neg_inv(m_neg_inv),
        .out_valid(out_valid), .result(result)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [N-1:0] ref_mont(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] m);
        logic [2*N+1:0] x;
        x = (2*N+2)'(a) * (2*N+2)'(b);
        for (int i = 0; i < N; i++) begin
            if (x[0]) x = x + (2*N+2)'(m);
            x = x >> 1;
        end
        if (x >= (2*N+2)'(m)) x = x - (2*N+2)'(m);
        return x[N-1:0];
    endfunction

    function automatic logic [N-1:0] neg_inv(logic [N-1:0] m);
        logic [N-1:0] v;
        v = m;
        for (int i = 0; i < 6; i++) v = v * (64'd2 - m * v);
        return -v;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic issue(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] m, string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        op_a      = a;
        op_b      = b;
        modulus   = m;
        m_neg_inv = neg_inv(m);
        exp_val_q.push_back(ref_mont(a, b, m));
        exp_cyc_q.push_back(cyc + 2);
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle(int unsigned n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: sample 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (exp_val_q.size() == 0) begin
                    check("R8 unexpected out_valid", {63'b0, out_valid}, 64'd0);
                end else begin
                    check({exp_tag_q[0], " R1 cycle"}, 64'(cyc), 64'(exp_cyc_q[0]));
                    check({exp_tag_q[0], " R2 value"}, result, exp_val_q[0]);
                    void'(exp_val_q.pop_front());
                    void'(exp_cyc_q.pop_front());
                    void'(exp_tag_q.pop_front());
                end
            end else if (exp_cyc_q.size() != 0 && exp_cyc_q[0] <= cyc) begin
                check({exp_tag_q[0], " R1 missing out_valid"}, 64'd0, 64'd1);
                void'(exp_val_q.pop_front());
                void'(exp_cyc_q.pop_front());
                void'(exp_tag_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [N-1:0] m, a, b, mbig, msmall;
        seed = 32'd7;
        void'($urandom(seed));

        // R6: reset state
        repeat (3) @(negedge clk);
        check("R6 out_valid in reset", {63'b0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 out_valid after reset", {63'b0, out_valid}, 64'd0);

        mbig = 64'hFFFF_FFFF_FFFF_FFC5;
        // R7: operands at M-1 with modulus near 2^N
        issue(mbig - 1, mbig - 1, mbig, "R7 max operands");
        issue(64'd1, mbig - 1, mbig, "R7 one by max");
        // R4: zero low half of the product
        issue(64'h1_0000_0000, 64'h1_0000_0000, mbig, "R4 T0 zero");
        issue(64'd0, mbig - 1, mbig, "R4 zero operand");
        issue(64'd0, 64'd0, 64'd3, "R4 zeros small modulus");
        issue(64'd1, 64'd1, mbig, "R2 one by one");
        idle(4);
        // R8: gap produces no result
        check("R8 idle out_valid", {63'b0, out_valid}, 64'd0);

        // R5: alternating moduli on consecutive cycles
        msmall = 64'h0000_0001_0000_0007;
        for (int i = 0; i < 20; i++) begin
            m = (i % 2 == 0) ? mbig : msmall;
            a = {$urandom, $urandom} % m;
            b = {$urandom, $urandom} % m;
            issue(a, b, m, "R5 alternating moduli");
        end
        idle(3);

        // R2/R3: random odd moduli, random gaps
        for (int i = 0; i < 400; i++) begin
            m = {$urandom, $urandom} | 64'd1;
            if (i % 3 == 0) m[N-1] = 1'b1;
            case (i % 5)
                0: begin a = m - 1; b = {$urandom, $urandom} % m; end
                1: begin a = 64'd1; b = {$urandom, $urandom} % m; end
                default: begin a = {$urandom, $urandom} % m; b = {$urandom, $urandom} % m; end
            endcase
            issue(a, b, m, "R2 R3 random");
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(5);
        check("R8 final idle", {63'b0, out_valid}, 64'd0);
        check("R1 all results returned", 64'(exp_val_q.size()), 64'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule